// File: doc/BRIEF.md
# Converter Result Buffer with Transfer Engine

This block moves 16-bit results from a fast converter into system memory. Each result arrives with a one-cycle valid strobe in the converter clock domain. It enters a 64-entry first-in first-out buffer that crosses into the system clock domain. As soon as an entry is visible on the system side, it moves into a single readable data register.

The data register is emptied in one of two ways, chosen by a disable input. With the disable low, the transfer engine is in charge. It is armed with a start address and a result count. It writes each result to a plain memory write port, advancing the byte address by two per result, and pulses a done output after the last write. With the disable high, a CPU read strobe takes the register's value and brings forward the next result.

When a result arrives and the buffer is full, that result is discarded. This sets a sticky overflow flag in the system domain, which also serves as a level interrupt. Only a write-one-to-clear strobe clears the flag. The buffer is deep enough to keep pace whenever the system clock is at least the sample rate.

Top module: `crb_result_xfer`

## Requirements
- R1: After reset, `rd_valid`, `mem_we`, `xfer_done` and `ovf_irq` are all low.
- R2: Results leave the block, on either drain path, in the order they arrived.
- R3: In CPU mode with no reads, 65 unread results are kept (64 in the buffer plus one in the data register), and every later result is discarded.
- R4: A result that arrives while the buffer is full is dropped and sets `ovf_irq`, whichever drain mode is active.
- R5: `ovf_irq` stays high until a one-cycle `ovf_clr` pulse in a cycle with no new drop. Afterwards it reads low.
- R6: With `eng_disable` = 1, `rd_valid` is high whenever the data register holds a result. `rd_data` holds its value until a `cpu_rd` pulse consumes it. After that pulse the next result, if one is buffered, appears one cycle later.
- R7: With `eng_disable` = 0, `cpu_rd` has no effect: `rd_valid` and `rd_data` are unchanged.
- R8: A `xfer_start` pulse loads `xfer_base` and `xfer_count`. The k-th result afterwards (k from 0) is written with a single-cycle `mem_we` at `mem_addr` = base + 2k, with `mem_wdata` equal to the result. No write occurs while `eng_disable` = 1.
- R9: After `xfer_count` writes the engine stops. `xfer_done` is high for exactly one cycle, the cycle of the last `mem_we`. A start with a count of zero writes nothing and pulses `xfer_done` in the following cycle.
- R10: When the engine is active and the sample rate is at or below the system clock, a continuous stream with one result per converter cycle is written in full without overflow.
- R11: With the engine enabled but no transfer active, arriving results stay in the data register and buffer, and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnv_clk | input | 1 | Converter domain clock |
| sys_clk | input | 1 | System domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| smp_valid | input | 1 | Result strobe (converter domain) |
| smp_data | input | 16 | Result value (converter domain) |
| eng_disable | input | 1 | 1 selects CPU draining, 0 selects the transfer engine |
| xfer_start | input | 1 | Pulse that arms the engine with base and count |
| xfer_base | input | 16 | Byte start address for the transfer |
| xfer_count | input | 12 | Number of results to transfer |
| cpu_rd | input | 1 | CPU read strobe for the data register |
| rd_data | output | 16 | Data register value |
| rd_valid | output | 1 | Data register holds an unread result |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| xfer_done | output | 1 | One-cycle pulse when the transfer count is used up |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| ovf_irq | output | 1 | Sticky overflow flag and level interrupt |

## Verification
The assertions assume four things about the inputs:
- `cpu_rd` and `ovf_clr` are single system-cycle pulses, driven away from the clock edge.
- `xfer_start` is never raised in the same cycle as a final engine write.
- `eng_disable` changes only between transactions.
- The converter strobe never runs faster than one result per converter cycle.

The stimulus respects these rules. Every input changes on the falling edge of its own domain's clock. The stimulus arms a transfer and then waits for its done pulse before touching the mode input. For the overflow case it holds off CPU reads until the buffer has had many cycles to settle. This keeps the conservative full and empty flags from producing off-by-one counts.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef enum logic {
    MODE_ENGINE = 1'b0,
    MODE_CPU    = 1'b1
  } crb_mode_e;
endpackage

// File: rtl/crb_rst_sync.sv
module crb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/crb_sync2.sv
module crb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/crb_async_fifo.sv
module crb_async_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 64
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  output logic          wr_drop_tgl,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DW-1:0] store [DEPTH];

  logic [PW-1:0] wbin_q, wbin_nx, wgray_q, rgray_w;
  logic [PW-1:0] rbin_q, rbin_nx, rgray_q, wgray_r;
  logic          drop_q, drop_nx;
  logic          push;

  // write domain
  assign wr_full = (wgray_q == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
  assign push    = wr_en && !wr_full;

  always_comb begin
    wbin_nx = wbin_q;
    drop_nx = drop_q;
    if (push)               wbin_nx = wbin_q + PW'(1);
    if (wr_en && wr_full)   drop_nx = ~drop_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      drop_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= to_gray(wbin_nx);
      drop_q  <= drop_nx;
    end
  end

  always_ff @(posedge wclk) begin
    if (push) store[wbin_q[AW-1:0]] <= wr_data;
  end

  assign wr_drop_tgl = drop_q;

  crb_sync2 #(.W(PW)) u_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w)
  );

  // read domain
  assign rd_empty = (rgray_q == wgray_r);
  assign rd_data  = store[rbin_q[AW-1:0]];

  always_comb begin
    rbin_nx = rbin_q;
    if (rd_pop && !rd_empty) rbin_nx = rbin_q + PW'(1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= to_gray(rbin_nx);
    end
  end

  crb_sync2 #(.W(PW)) u_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r)
  );
endmodule

// File: rtl/crb_drain.sv
module crb_drain
  import crb_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic [DW-1:0]     fifo_data,
  output logic              fifo_pop,
  input  logic              eng_disable,
  input  logic              xfer_start,
  input  logic [ADDR_W-1:0] xfer_base,
  input  logic [CNT_W-1:0]  xfer_count,
  input  logic              cpu_rd,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              xfer_done,
  output logic              eng_busy
);
  localparam int ADDR_STEP = DW / 8;

  crb_mode_e mode;

  logic [DW-1:0]     dreg_q, dreg_nx;
  logic              dvld_q, dvld_nx;
  logic              busy_q, busy_nx;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic              done_nx;
  logic              fire, cpu_take, consume;

  assign mode     = eng_disable ? MODE_CPU : MODE_ENGINE;
  assign fire     = (mode == MODE_ENGINE) && busy_q && dvld_q;
  assign cpu_take = (mode == MODE_CPU) && cpu_rd && dvld_q;
  assign consume  = fire || cpu_take;
  assign fifo_pop = !fifo_empty && (!dvld_q || consume);

  // data register
  always_comb begin
    dreg_nx = dreg_q;
    dvld_nx = dvld_q;
    if (fifo_pop) begin
      dreg_nx = fifo_data;
      dvld_nx = 1'b1;
    end else if (consume) begin
      dvld_nx = 1'b0;
    end
  end

  // transfer engine
  always_comb begin
    busy_nx = busy_q;
    addr_nx = addr_q;
    cnt_nx  = cnt_q;
    done_nx = 1'b0;
    if (xfer_start) begin
      addr_nx = xfer_base;
      cnt_nx  = xfer_count;
      busy_nx = (xfer_count != '0);
      done_nx = (xfer_count == '0);
    end else if (fire) begin
      addr_nx = addr_q + ADDR_W'(ADDR_STEP);
      cnt_nx  = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_nx = 1'b0;
        done_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q    <= '0;
      dvld_q    <= 1'b0;
      busy_q    <= 1'b0;
      addr_q    <= '0;
      cnt_q     <= '0;
      xfer_done <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      dreg_q    <= dreg_nx;
      dvld_q    <= dvld_nx;
      busy_q    <= busy_nx;
      addr_q    <= addr_nx;
      cnt_q     <= cnt_nx;
      xfer_done <= done_nx;
      mem_we    <= fire;
      if (fire) begin
        mem_addr  <= addr_q;
        mem_wdata <= dreg_q;
      end
    end
  end

  assign rd_data  = dreg_q;
  assign rd_valid = dvld_q;
  assign eng_busy = busy_q;
endmodule

// File: rtl/crb_result_xfer.sv
module crb_result_xfer #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              cnv_clk,
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              eng_disable,
  input  logic              xfer_start,
  input  logic [ADDR_W-1:0] xfer_base,
  input  logic [CNT_W-1:0]  xfer_count,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              xfer_done,
  input  logic              ovf_clr,
  output logic              ovf_irq
);
  logic              cnv_rst_n, sys_rst_n;
  logic              wr_full, drop_tgl, drop_sys;
  logic              fifo_empty, fifo_pop;
  logic [DATA_W-1:0] fifo_data;
  logic              eng_busy;
  logic              drop_prev_q, ovf_q, ovf_nx, drop_evt;

  crb_rst_sync u_cnv_rst (.clk(cnv_clk), .arst_n(rst_n), .srst_n(cnv_rst_n));
  crb_rst_sync u_sys_rst (.clk(sys_clk), .arst_n(rst_n), .srst_n(sys_rst_n));

  crb_async_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .wclk(cnv_clk), .wrst_n(cnv_rst_n), .wr_en(smp_valid), .wr_data(smp_data),
    .wr_full(wr_full), .wr_drop_tgl(drop_tgl),
    .rclk(sys_clk), .rrst_n(sys_rst_n), .rd_pop(fifo_pop),
    .rd_data(fifo_data), .rd_empty(fifo_empty)
  );

  crb_drain #(.DW(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_drain (
    .clk(sys_clk), .rst_n(sys_rst_n),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .eng_disable(eng_disable), .xfer_start(xfer_start),
    .xfer_base(xfer_base), .xfer_count(xfer_count), .cpu_rd(cpu_rd),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .xfer_done(xfer_done), .eng_busy(eng_busy)
  );

  // drop events cross as a toggle
  crb_sync2 #(.W(1)) u_drop_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(drop_tgl), .q(drop_sys)
  );

  assign drop_evt = drop_sys ^ drop_prev_q;

  always_comb begin
    ovf_nx = ovf_q;
    if (ovf_clr)  ovf_nx = 1'b0;
    if (drop_evt) ovf_nx = 1'b1;
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      drop_prev_q <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      drop_prev_q <= drop_sys;
      ovf_q       <= ovf_nx;
    end
  end

  assign ovf_irq = ovf_q;
endmodule

// File: rtl/crb_result_xfer_chk.sv
module crb_result_xfer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_disable,
  input logic          cpu_rd,
  input logic          ovf_clr,
  input logic          ovf_irq,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          mem_we,
  input logic          xfer_done,
  input logic          eng_busy
);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq && !ovf_clr |=> ovf_irq);

  // R6
  cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && eng_disable && !cpu_rd |=> rd_valid && $stable(rd_data));

  // R7
  cpu_rd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !eng_disable && !eng_busy && cpu_rd |=> rd_valid && $stable(rd_data));

  // R8
  no_write_in_cpu_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(eng_disable));

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !eng_busy);
endmodule

bind crb_result_xfer crb_result_xfer_chk #(.DW(DATA_W)) u_chk (
  .clk(sys_clk), .rst_n(sys_rst_n), .eng_disable(eng_disable),
  .cpu_rd(cpu_rd), .ovf_clr(ovf_clr), .ovf_irq(ovf_irq),
  .rd_valid(rd_valid), .rd_data(rd_data), .mem_we(mem_we),
  .xfer_done(xfer_done), .eng_busy(eng_busy)
);

// File: tb/tb_crb_result_xfer.sv
`timescale 1ns/1ps
module tb_crb_result_xfer;
  logic        cnv_clk = 1'b0, sys_clk = 1'b0, rst_n = 1'b0;
  logic        smp_valid = 1'b0, eng_disable = 1'b0, xfer_start = 1'b0;
  logic        cpu_rd = 1'b0, ovf_clr = 1'b0;
  logic [15:0] smp_data = '0, xfer_base = '0;
  logic [11:0] xfer_count = '0;
  logic [15:0] rd_data, mem_addr, mem_wdata;
  logic        rd_valid, mem_we, xfer_done, ovf_irq;

  int checks = 0, fails = 0;
  int wn = 0, dn = 0;
  logic [15:0] wr_addr [256];
  logic [15:0] wr_data [256];

  always #2   sys_clk = ~sys_clk;
  always #3.5 cnv_clk = ~cnv_clk;

  crb_result_xfer dut (
    .cnv_clk(cnv_clk), .sys_clk(sys_clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_data(smp_data), .eng_disable(eng_disable),
    .xfer_start(xfer_start), .xfer_base(xfer_base), .xfer_count(xfer_count),
    .cpu_rd(cpu_rd), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .xfer_done(xfer_done), .ovf_clr(ovf_clr), .ovf_irq(ovf_irq)
  );

  function automatic logic [15:0] val(input int k);
    return 16'((k * 40503 + 7) & 32'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge sys_clk) begin
    if (mem_we && wn < 256) begin
      wr_addr[wn] = mem_addr;
      wr_data[wn] = mem_wdata;
      wn++;
    end
    if (xfer_done) dn++;
  end

  task automatic send_n(input int first, input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge cnv_clk);
      smp_valid = 1'b1;
      smp_data  = val(first + k);
      if (gap > 0) begin
        @(negedge cnv_clk);
        smp_valid = 1'b0;
        repeat (gap - 1) @(negedge cnv_clk);
      end
    end
    @(negedge cnv_clk);
    smp_valid = 1'b0;
  endtask

  task automatic cpu_read(input logic [15:0] exp, input string req);
    @(negedge sys_clk);
    chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
    chk(rd_data == exp, req, int'(rd_data), int'(exp));
    cpu_rd = 1'b1;
    @(negedge sys_clk);
    cpu_rd = 1'b0;
  endtask

  task automatic start_xfer(input logic [15:0] base, input logic [11:0] cnt);
    @(negedge sys_clk);
    xfer_base = base; xfer_count = cnt; xfer_start = 1'b1;
    @(negedge sys_clk);
    xfer_start = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int cnts [4] = '{1, 3, 8, 20};
    settle(3);
    rst_n = 1'b1;
    settle(8);
    // R1 reset state
    chk(rd_valid == 0, "R1 rd_valid", int'(rd_valid), 0);
    chk(mem_we == 0, "R1 mem_we", int'(mem_we), 0);
    chk(xfer_done == 0, "R1 xfer_done", int'(xfer_done), 0);
    chk(ovf_irq == 0, "R1 ovf_irq", int'(ovf_irq), 0);

    // R2 / R6: CPU drain keeps order
    eng_disable = 1'b1;
    send_n(0, 10, 2);
    settle(12);
    for (int k = 0; k < 10; k++) cpu_read(val(k), "R2 R6 cpu order");
    settle(2);
    chk(rd_valid == 0, "R6 empty after reads", int'(rd_valid), 0);
    chk(ovf_irq == 0, "R4 no overflow", int'(ovf_irq), 0);
    chk(wn == 0, "R8 no writes in cpu mode", wn, 0);

    // R3 / R4 / R5: fill without reads
    send_n(100, 70, 1);
    settle(12);
    chk(ovf_irq == 1, "R4 overflow set", int'(ovf_irq), 1);
    for (int k = 0; k < 65; k++) cpu_read(val(100 + k), "R3 retained");
    settle(2);
    chk(rd_valid == 0, "R3 later results discarded", int'(rd_valid), 0);
    chk(ovf_irq == 1, "R5 still set", int'(ovf_irq), 1);
    @(negedge sys_clk); ovf_clr = 1'b1;
    @(negedge sys_clk); ovf_clr = 1'b0;
    settle(1);
    chk(ovf_irq == 0, "R5 cleared", int'(ovf_irq), 0);

    // R11 / R7: engine idle holds data, cpu_rd ignored
    eng_disable = 1'b0;
    wn = 0; dn = 0;
    send_n(300, 1, 1);
    settle(10);
    chk(rd_valid == 1, "R11 held", int'(rd_valid), 1);
    chk(wn == 0, "R11 no write", wn, 0);
    @(negedge sys_clk); cpu_rd = 1'b1;
    @(negedge sys_clk); cpu_rd = 1'b0;
    chk(rd_valid == 1, "R7 valid kept", int'(rd_valid), 1);
    chk(rd_data == val(300), "R7 data kept", int'(rd_data), int'(val(300)));
    start_xfer(16'h0040, 12'd1);
    settle(4);
    chk(wn == 1, "R8 single write", wn, 1);
    chk(wr_addr[0] == 16'h0040, "R8 addr", int'(wr_addr[0]), 16'h40);
    chk(wr_data[0] == val(300), "R8 data", int'(wr_data[0]), int'(val(300)));
    chk(dn == 1, "R9 done", dn, 1);

    // R8 / R9 sweep over counts
    for (int c = 0; c < 4; c++) begin
      int n = cnts[c];
      logic [15:0] base = 16'(16'h1000 * (c + 1) + 2 * c);
      int seed = 1000 + 100 * c;
      wn = 0; dn = 0;
      start_xfer(base, 12'(n));
      send_n(seed, n + 2, 1);
      settle(20);
      chk(wn == n, "R9 write count", wn, n);
      for (int k = 0; k < n; k++) begin
        chk(wr_addr[k] == 16'(base + 2 * k), "R8 address step", int'(wr_addr[k]), int'(16'(base + 2 * k)));
        chk(wr_data[k] == val(seed + k), "R2 R8 write data", int'(wr_data[k]), int'(val(seed + k)));
      end
      chk(dn == 1, "R9 single done", dn, 1);
      chk(rd_valid == 1 && rd_data == val(seed + n), "R11 leftover held", int'(rd_data), int'(val(seed + n)));
      eng_disable = 1'b1;
      cpu_read(val(seed + n), "R2 leftover 0");
      cpu_read(val(seed + n + 1), "R2 leftover 1");
      eng_disable = 1'b0;
    end

    // R10 continuous stream
    wn = 0; dn = 0;
    start_xfer(16'h8000, 12'd100);
    send_n(5000, 100, 0);
    settle(40);
    chk(wn == 100, "R10 all written", wn, 100);
    for (int k = 0; k < 100; k++)
      chk(wr_data[k] == val(5000 + k) && wr_addr[k] == 16'(16'h8000 + 2 * k),
          "R10 stream", int'(wr_data[k]), int'(val(5000 + k)));
    chk(ovf_irq == 0, "R10 no overflow", int'(ovf_irq), 0);
    chk(dn == 1, "R9 stream done", dn, 1);

    // R9 zero count
    wn = 0; dn = 0;
    start_xfer(16'h0100, 12'd0);
    settle(4);
    chk(dn == 1, "R9 zero count done", dn, 1);
    chk(wn == 0, "R9 zero count writes", wn, 0);

    summary();
  end
endmodule